// File: doc/BRIEF.md
# Dual-Input Edge Capture Timer

This block is a 16-bit counter with a programmable prescaler, able to count up or down within a programmable limit. Two capture channels watch pins taken from a bank of general-purpose inputs. When a channel sees its chosen edge, it copies the running count into its own capture register. A capture can also raise an interrupt that software may mask.

Software drives the block through a simple register port. Writes are synchronous: address, data and a write strobe. Reads are combinational: the addressed register appears on the read-data bus in the same cycle. The counting base is either every system clock or a slow-clock pulse `lf_tick`. The slow pulse is one system-clock cycle wide, comes from the 32 kHz domain and is already synchronous to `clk`. Each capture channel is fed from the pin bank through a pin selector, a two-flop synchronizer and an edge detector.

Register map (word addresses): 0 control, 1 limit, 2 prescale, 3 pin select A, 4 pin select B, 5 count (read-only), 6 live prescaler count (read-only), 7 capture A (read-only), 8 capture B (read-only), 9 status. Control bits: [0] run, [1] count down, [2] free-run, [3] channel A falling edge, [4] channel B falling edge, [5] interrupt enable, [6] system-clock base. Status bits: [0] synchronized level A, [1] synchronized level B, [2] pending A, [3] pending B; writing 1 to bit 2 or 3 of address 9 clears that pending flag.

Top module: `capture_timer`

## Requirements
- R1: While control bit 0 (run) is clear, the counter and the prescaler hold their values. Once run is set, counting starts from where they stopped.
- R2: With control bit 1 clear and bit 2 clear, each tick increments the count. A tick taken while the count is at or above the limit (address 1) returns it to 0. Over N ticks from 0 the count is N mod (limit+1).
- R3: With control bit 1 set, each tick decrements the count, and a tick at 0 loads the limit. From 0, N ticks give (limit+1 - N mod (limit+1)) mod (limit+1). Bit 2 has no effect in this direction.
- R4: With control bit 2 set while counting up, the limit is ignored and the count wraps from 65535 to 0.
- R5: One tick occurs every (prescale+1) counting-base pulses. Address 6 reads the live prescaler count, which is N mod (prescale+1) after N base pulses with run set.
- R6: With control bit 6 set, every system clock is a base pulse. With it clear, only cycles with `lf_tick` high are base pulses.
- R7: A pin-select value s from 1 to 37 routes pins[s-1] to the channel. The value 0, and any value above 37, disconnect the channel: its input level reads 0 and it never captures.
- R8: A pin change driven before clock edge k is captured at edge k+2. The capture register then holds the count from just before that edge, which is the count seen before edge k plus 2 when a tick occurs on every edge. The edge is rising when the channel's polarity bit (3 for A, 4 for B) is clear, falling when it is set, and the opposite edge captures nothing.
- R9: Status bits 0 and 1 show the synchronized level of channels A and B, two clock edges after the pin changes.
- R10: A capture sets the channel's pending flag. `irq` is high while control bit 5 is set and any pending flag is set. Writing 1 to status bit 2 or 3 clears that flag, unless a capture on the same channel falls on the same edge.
- R11: After reset every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_tick | input | 1 | One-cycle pulse marking each 32 kHz period |
| pins | input | 37 | General-purpose pin bank |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Read data for rd_addr, combinational |
| irq | output | 1 | Capture interrupt |

## Verification
A control write takes effect on the edge that takes it. From then on the count and the prescaler read-back are exact functions of how many edges have passed, and the bench samples them at the falling edge after each rising edge. Input levels are due two edges after a pin change, and a capture and its interrupt three edges after it. The bench drives pins at a falling edge, notes the count at that moment, and reads the status after the second edge and the capture register and `irq` after the third. A cleared pending flag is checked one edge after the write.

// File: rtl/capture_timer.sv
module capture_timer #(
  parameter int W  = 16,
  parameter int NP = 37,
  parameter int SW = 6,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lf_tick,
  input  logic [NP-1:0] pins,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          irq
);
  localparam int CW = 7;
  localparam logic [AW-1:0] A_CTL = AW'(0), A_LIM = AW'(1), A_PRE = AW'(2),
    A_SELA = AW'(3), A_SELB = AW'(4), A_CNT = AW'(5), A_PLV = AW'(6),
    A_CAPA = AW'(7), A_CAPB = AW'(8), A_ST = AW'(9);

  logic [CW-1:0] ctl;
  logic [W-1:0]  limit, prescale, pre, cnt, cap_a, cap_b;
  logic [SW-1:0] sel_a, sel_b;
  logic [2:0]    sy_a, sy_b;
  logic          pend_a, pend_b;

  wire run   = ctl[0];
  wire down  = ctl[1];
  wire free  = ctl[2];
  wire fal_a = ctl[3];
  wire fal_b = ctl[4];
  wire ien   = ctl[5];
  wire fast  = ctl[6];

  wire adv  = run & (fast | lf_tick);
  wire tick = adv & (pre >= prescale);

  wire [NP:0] pin_x = {pins, 1'b0};
  wire raw_a = (sel_a <= SW'(NP)) ? pin_x[sel_a] : 1'b0;
  wire raw_b = (sel_b <= SW'(NP)) ? pin_x[sel_b] : 1'b0;

  wire ev_a = fal_a ? (~sy_a[1] & sy_a[2]) : (sy_a[1] & ~sy_a[2]);
  wire ev_b = fal_b ? (~sy_b[1] & sy_b[2]) : (sy_b[1] & ~sy_b[2]);

  wire wr_st = wr_en && wr_addr == A_ST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; limit <= '0; prescale <= '0; sel_a <= '0; sel_b <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTL:  ctl      <= wr_data[CW-1:0];
        A_LIM:  limit    <= wr_data;
        A_PRE:  prescale <= wr_data;
        A_SELA: sel_a    <= wr_data[SW-1:0];
        A_SELB: sel_b    <= wr_data[SW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      if (adv) pre <= tick ? '0 : pre + W'(1);
      if (tick) begin
        if (down)                        cnt <= (cnt == '0) ? limit : cnt - W'(1);
        else if (!free && cnt >= limit)  cnt <= '0;
        else                             cnt <= cnt + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_a <= '0; sy_b <= '0; cap_a <= '0; cap_b <= '0;
      pend_a <= 1'b0; pend_b <= 1'b0;
    end else begin
      sy_a <= {sy_a[1:0], raw_a};
      sy_b <= {sy_b[1:0], raw_b};
      if (ev_a) cap_a <= cnt;
      if (ev_b) cap_b <= cnt;
      pend_a <= ev_a | (pend_a & ~(wr_st & wr_data[2]));
      pend_b <= ev_b | (pend_b & ~(wr_st & wr_data[3]));
    end
  end

  assign irq = ien & (pend_a | pend_b);

  always_comb begin
    case (rd_addr)
      A_CTL:   rd_data = W'(ctl);
      A_LIM:   rd_data = limit;
      A_PRE:   rd_data = prescale;
      A_SELA:  rd_data = W'(sel_a);
      A_SELB:  rd_data = W'(sel_b);
      A_CNT:   rd_data = cnt;
      A_PLV:   rd_data = pre;
      A_CAPA:  rd_data = cap_a;
      A_CAPB:  rd_data = cap_b;
      A_ST:    rd_data = W'({pend_b, pend_a, sy_b[1], sy_a[1]});
      default: rd_data = '0;
    endcase
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(cnt) && $stable(pre)));  // R1
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !down && !free && cnt >= limit) |=> cnt == '0);  // R2
  AST_DOWN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && down && cnt == '0) |=> cnt == $past(limit));  // R3
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !down && free && cnt == '1) |=> cnt == '0);  // R4
  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pre == '0);  // R5
  AST_CAP_A: assert property (@(posedge clk) disable iff (!rst_n)
    ev_a |=> (cap_a == $past(cnt) && pend_a));  // R8
  AST_CAP_B: assert property (@(posedge clk) disable iff (!rst_n)
    ev_b |=> (cap_b == $past(cnt) && pend_b));  // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && wr_data[2] && wr_data[3] && !ev_a && !ev_b) |=> !irq);  // R10
endmodule

// File: tb/capture_timer_bench.sv
module capture_timer_bench;
  logic        clk = 1'b0, rst_n = 1'b0, lf_tick = 1'b0, wr_en = 1'b0;
  logic [36:0] pins = '0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;
  int tests = 0, fails = 0;

  capture_timer u_capture_timer (.clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .pins(pins),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pins = '0; lf_tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [15:0] model(int t, int lim, bit dn);
    int m;
    m = t % (lim + 1);
    return dn ? 16'((lim + 1 - m) % (lim + 1)) : 16'(m);
  endfunction

  task automatic count_sweep(input int p, input int lim, input bit dn, input bit fr);
    logic [15:0] v;
    do_reset();
    wr(1, 16'(lim)); wr(2, 16'(p));
    wr(0, 16'h41 | (dn ? 16'h2 : 16'h0) | (fr ? 16'h4 : 16'h0));
    for (int n = 1; n <= 25; n++) begin
      @(posedge clk); @(negedge clk);
      rd(5, v); chk(dn ? "R3 down count" : "R2 up count", v, model(n / (p + 1), lim, dn));
      rd(6, v); chk("R5 prescaler live", v, 16'(n % (p + 1)));
    end
    wr(0, 16'h40);
    rd(5, v); chk("R1 stop edge", v, model(26 / (p + 1), lim, dn));
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(5, v); chk("R1 hold count", v, model(26 / (p + 1), lim, dn));
    rd(6, v); chk("R1 hold prescaler", v, 16'(26 % (p + 1)));
  endtask

  task automatic cap_once(input int ch, input int s);
    logic [15:0] c, v;
    wr(4'(3 + ch), 16'(s));
    repeat (3) @(negedge clk);
    wr(9, 16'hC);
    rd(5, c);
    pins[s-1] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(9, v); chk("R9 level", v & 16'(1 << ch), 16'(1 << ch));
    @(posedge clk); @(negedge clk);
    rd(4'(7 + ch), v); chk("R8 capture value", v, c + 16'd2);
    rd(9, v); chk("R10 pending", v & 16'(4 << ch), 16'(4 << ch));
    chk("R10 irq raised", 16'(irq), 16'd1);
    pins[s-1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'(7 + ch), v); chk("R8 opposite edge ignored", v, c + 16'd2);
  endtask

  initial begin
    logic [15:0] v, c, keep;
    do_reset();
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v); chk("R11 reset value", v, 16'd0);
    end
    chk("R11 irq low", 16'(irq), 16'd0);

    for (int p = 0; p < 3; p++)
      for (int l = 0; l < 6; l += 2) begin
        count_sweep(p, l + 1, 1'b0, 1'b0);
        count_sweep(p, l + 1, 1'b1, 1'b0);
      end
    count_sweep(1, 4, 1'b1, 1'b1);
    count_sweep(0, 0, 1'b0, 1'b0);

    do_reset();
    wr(1, 16'd3); wr(0, 16'h45);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(5, v); chk("R4 ignores limit", v, 16'd10);
    repeat (65526) @(posedge clk);
    @(negedge clk);
    rd(5, v); chk("R4 wraps at all ones", v, 16'd0);
    @(posedge clk); @(negedge clk);
    rd(5, v); chk("R4 after wrap", v, 16'd1);

    do_reset();
    wr(1, 16'd100); wr(2, 16'd1); wr(0, 16'h01);
    repeat (6) @(negedge clk);
    rd(5, v); chk("R6 no slow pulses", v, 16'd0);
    for (int k = 1; k <= 12; k++) begin
      lf_tick = 1'b1; @(negedge clk); lf_tick = 1'b0;
      repeat (2) @(negedge clk);
      rd(5, v); chk("R6 slow base count", v, 16'(k / 2));
      rd(6, v); chk("R6 slow prescaler", v, 16'(k % 2));
    end

    do_reset();
    wr(1, 16'hFFFF); wr(0, 16'h61);
    for (int s = 1; s <= 37; s++) cap_once(0, s);
    for (int s = 1; s <= 37; s++) cap_once(1, s);

    wr(9, 16'hC);
    @(negedge clk);
    chk("R10 irq cleared", 16'(irq), 16'd0);

    wr(0, 16'h69); wr(3, 16'd5);
    repeat (3) @(negedge clk);
    rd(7, keep);
    pins[4] = 1'b1;
    repeat (4) @(negedge clk);
    rd(7, v); chk("R8 rising ignored when falling set", v, keep);
    rd(9, v); chk("R8 no pending on rising", v & 16'h4, 16'h0);
    rd(5, c);
    pins[4] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(7, v); chk("R8 falling capture", v, c + 16'd2);
    wr(9, 16'hC);

    for (int q = 0; q < 2; q++) begin
      wr(3, q ? 16'd63 : 16'd0);
      rd(7, keep);
      pins = '1;
      repeat (3) @(negedge clk);
      rd(9, v); chk("R7 disabled level", v & 16'h1, 16'h0);
      pins = '0;
      repeat (4) @(negedge clk);
      rd(7, v); chk("R7 disabled no capture", v, keep);
      rd(9, v); chk("R7 disabled no pending", v & 16'h4, 16'h0);
    end

    wr(0, 16'h41); wr(4, 16'd37);
    repeat (3) @(negedge clk);
    wr(9, 16'hC);
    pins[36] = 1'b1;
    repeat (4) @(negedge clk);
    rd(9, v); chk("R10 pending while masked", v & 16'h8, 16'h8);
    chk("R10 irq masked", 16'(irq), 16'd0);
    wr(0, 16'h61);
    chk("R10 irq on unmask", 16'(irq), 16'd1);
    wr(9, 16'h8);
    rd(9, v); chk("R10 clear pending", v & 16'h8, 16'h0);
    chk("R10 irq after clear", 16'(irq), 16'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule